// File: doc/BRIEF.md
# Bus Master Request and Grant Sequencer

This block sits on the master side of a slot-dedicated request/acknowledge pair. A local agent raises `want` when it needs the shared bus. The sequencer then drives an active-low request, waits until the arbiter's active-low grant is sampled, and enables the master's address and control drivers at the proper half of the bus clock. It lets go of the bus when the agent reports `done`, or when a preemption deadline runs out after the arbiter has withdrawn the grant. It keeps the drivers on until the bus can be safely floated, and it then enforces a minimum gap before the next request.

The bus clock is not used as a register clock. The block runs on a fast core clock and acts only in cycles flagged by `rise_en` (bus clock rising edge) or `fall_en` (bus clock falling edge). Its states are Idle, Request, Granted, Own, Float, Drain and Holdoff. The transitions are: ask (Idle to Request, on a falling enable with `want` high); win (Request to Granted, on a rising enable with grant low); drive (Granted to Own, on the next falling enable); release (Own to Float or Drain, on a falling enable with `done` high or the preemption counter saturated; the target is Drain when `cyc_active` is high); float (Float to Holdoff, on the next rising enable); finish (Drain to Holdoff, on the first rising enable with `cyc_active` low); and rearm (Holdoff to Idle, once the gap counter is full).

Top module: `busreq_sequencer`

## Requirements
- R1: In reset and right after it, `req_n` is 1, `drv_en` is 0 and `preempt_err` is 0.
- R2: From Idle with `want` high, `req_n` goes to 0 at the first falling enable. A rising enable alone never asserts the request.
- R3: The request stays low until grant is seen low on a rising enable. A grant that is low only during falling-enable cycles has no effect, and `drv_en` stays 0.
- R4: `drv_en` becomes 1 at the first falling enable after the rising enable that sampled the grant low. `req_n` is still 0 at that point.
- R5: While owning, `req_n` returns to 1 at the first falling enable at which `done` is 1. A `done` seen only on a rising enable does not release the bus.
- R6: If `cyc_active` is 0 at release, `drv_en` returns to 0 at the very next rising enable.
- R7: If `cyc_active` is 1 at release, `drv_en` stays 1 through every rising enable with `cyc_active` high. It returns to 0 at the first rising enable with `cyc_active` low.
- R8: While owning, each rising enable that sees grant high (`grant_n`=1) is counted; the count is not reset when the grant returns. When the count reaches PREEMPT_LIMIT, `preempt_err` becomes 1 and `req_n` returns to 1 at the next falling enable, even with `done` at 0. If the agent releases earlier, `preempt_err` stays 0.
- R9: After a release, the request is asserted again only once HOLDOFF_CLKS rising enables have passed since that release. With `want` held high, it is asserted at the first falling enable after that.
- R10: `preempt_err` stays set after a forced release and is cleared by the next ask transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rise_en | input | 1 | One-cycle flag marking a bus clock rising edge |
| fall_en | input | 1 | One-cycle flag marking a bus clock falling edge |
| grant_n | input | 1 | Slot grant from the arbiter, active low |
| cyc_active | input | 1 | A bus cycle is in flight |
| want | input | 1 | Local agent needs the bus |
| done | input | 1 | Local agent has finished with the bus |
| req_n | output | 1 | Slot request to the arbiter, active low |
| drv_en | output | 1 | Enable for the master's address and control drivers |
| preempt_err | output | 1 | Sticky flag: the release deadline expired before the agent finished |

## Verification
The hardest situations to reach are the forced release and the interplay of a drained cycle with the holdoff gap. Both depend on how many rising enables have passed in a particular state, not on any single input. The stimulus steps the bus clock one half-period at a time. It sweeps the grant delay, the owning length and the number of drain edges, and it computes the cycle in which the next request must appear from the number of rising edges since the release. For preemption, it withdraws the grant and counts rising edges to exactly one short of the limit and to the limit itself. It covers both an early `done` and none at all, each with and without a cycle in flight.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_GNT,
        ST_OWN,
        ST_FLOAT,
        ST_DRAIN,
        ST_HOLD
    } seq_state_t;

endpackage

// File: rtl/busreq_satcnt.sv
module busreq_satcnt #(
    parameter int MAX        = 64,
    parameter bit RESET_FULL = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         inc,
    output logic [$clog2(MAX+1)-1:0]     cnt,
    output logic                         full
);
    localparam int W = $clog2(MAX + 1);
    localparam logic [W-1:0] MAXV = W'(MAX);

    assign full = (cnt == MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= RESET_FULL ? MAXV : '0;
        else if (clr)
            cnt <= '0;
        else if (inc && !full)
            cnt <= cnt + W'(1);
    end

    // R8/R9 counters step by exactly one on a qualifying edge
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !full) |=> (cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/busreq_fsm.sv
module busreq_fsm
    import busreq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_en,
    input  logic        fall_en,
    input  logic        grant_n,
    input  logic        cyc_active,
    input  logic        want,
    input  logic        done,
    input  logic        pre_full,
    input  logic        gap_full,
    output seq_state_t  state,
    output logic        req_n,
    output logic        drv_en,
    output logic        preempt_err
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (fall_en && want)                nxt = ST_REQ;
            ST_REQ:   if (rise_en && !grant_n)            nxt = ST_GNT;
            ST_GNT:   if (fall_en)                        nxt = ST_OWN;
            ST_OWN:   if (fall_en && (done || pre_full))
                          nxt = cyc_active ? ST_DRAIN : ST_FLOAT;
            ST_FLOAT: if (rise_en)                        nxt = ST_HOLD;
            ST_DRAIN: if (rise_en && !cyc_active)         nxt = ST_HOLD;
            ST_HOLD:  if (gap_full)                       nxt = ST_IDLE;
            default:                                      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        req_n  = 1'b1;
        drv_en = 1'b0;
        unique case (state)
            ST_REQ, ST_GNT:     req_n  = 1'b0;
            ST_OWN: begin
                                req_n  = 1'b0;
                                drv_en = 1'b1;
            end
            ST_FLOAT, ST_DRAIN: drv_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            preempt_err <= 1'b0;
        else if (state == ST_IDLE && nxt == ST_REQ)
            preempt_err <= 1'b0;
        else if (state == ST_OWN && pre_full)
            preempt_err <= 1'b1;
    end

    assert_req_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_n) || $rose(req_n)) |-> $past(fall_en));

    assert_drive_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> ($past(fall_en) && !req_n));

    assert_drive_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> ($past(rise_en) && req_n));

    assert_err_owning_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preempt_err) |-> $past(!req_n));

endmodule

// File: rtl/busreq_sequencer.sv
module busreq_sequencer
    import busreq_pkg::*;
#(
    parameter int PREEMPT_LIMIT = 64,
    parameter int HOLDOFF_CLKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_en,
    input  logic fall_en,
    input  logic grant_n,
    input  logic cyc_active,
    input  logic want,
    input  logic done,
    output logic req_n,
    output logic drv_en,
    output logic preempt_err
);
    localparam int PW = $clog2(PREEMPT_LIMIT + 1);
    localparam int GW = $clog2(HOLDOFF_CLKS + 1);

    seq_state_t        state;
    logic [PW-1:0]     pre_cnt;
    logic [GW-1:0]     gap_cnt;
    logic              pre_full;
    logic              gap_full;
    logic              pre_inc;
    logic              gap_inc;
    logic              owning;

    assign owning  = (state == ST_OWN);
    assign pre_inc = rise_en && grant_n && owning;
    assign gap_inc = rise_en && (state == ST_FLOAT || state == ST_DRAIN || state == ST_HOLD);

    busreq_satcnt #(.MAX(PREEMPT_LIMIT), .RESET_FULL(1'b0)) u_preempt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!owning),
        .inc   (pre_inc),
        .cnt   (pre_cnt),
        .full  (pre_full)
    );

    busreq_satcnt #(.MAX(HOLDOFF_CLKS), .RESET_FULL(1'b1)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (owning),
        .inc   (gap_inc),
        .cnt   (gap_cnt),
        .full  (gap_full)
    );

    busreq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_en     (rise_en),
        .fall_en     (fall_en),
        .grant_n     (grant_n),
        .cyc_active  (cyc_active),
        .want        (want),
        .done        (done),
        .pre_full    (pre_full),
        .gap_full    (gap_full),
        .state       (state),
        .req_n       (req_n),
        .drv_en      (drv_en),
        .preempt_err (preempt_err)
    );

    assert_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> gap_full);

    assert_force_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owning && pre_full && fall_en) |=> req_n);

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (req_n && !drv_en));

endmodule

// File: tb/busreq_sequencer_test.sv
`timescale 1ns/1ps
module busreq_sequencer_test;
    localparam int LIM  = 6;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rise_en = 1'b0, fall_en = 1'b0;
    logic grant_n = 1'b1, cyc_active = 1'b0, want = 1'b0, done = 1'b0;
    logic req_n, drv_en, preempt_err;

    int total = 0;
    int fails = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    busreq_sequencer #(.PREEMPT_LIMIT(LIM), .HOLDOFF_CLKS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .rise_en(rise_en), .fall_en(fall_en),
        .grant_n(grant_n), .cyc_active(cyc_active), .want(want), .done(done),
        .req_n(req_n), .drv_en(drv_en), .preempt_err(preempt_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input bit is_rise);
        @(negedge clk);
        rise_en = is_rise;
        fall_en = !is_rise;
        @(negedge clk);
        rise_en = 1'b0;
        fall_en = 1'b0;
        @(negedge clk);
    endtask

    // starts right after the release fall; returns rising edges seen since release
    task automatic drain(input int cx, output int r);
        r = 0;
        for (int k = 0; k < cx; k++) begin
            cyc_active = 1'b1;
            tick(1'b1); r++;
            chk("R7 drivers held while cycle in flight", drv_en, 1);
            tick(1'b0);
        end
        cyc_active = 1'b0;
        tick(1'b1); r++;
        if (cx == 0) chk("R6 drivers float at next rise", drv_en, 0);
        else         chk("R7 drivers float at cycle end", drv_en, 0);
    endtask

    // starts right after a request was raised on a fall
    task automatic finish_quick();
        want = 1'b0;
        grant_n = 1'b0;
        tick(1'b1);
        tick(1'b0);
        chk("R4 drive after grant", drv_en, 1);
        done = 1'b1;
        tick(1'b1);
        tick(1'b0);
        chk("R5 release on done", req_n, 1);
        done = 1'b0;
        grant_n = 1'b1;
        tick(1'b1);
        chk("R6 float after idle release", drv_en, 0);
        tick(1'b0);
        tick(1'b1);
        tick(1'b0);
    endtask

    task automatic run_case(input int gd, input int ol, input int cx);
        int r;
        want = 1'b1;
        tick(1'b1);
        chk("R2 no request on rise", req_n, 1);
        tick(1'b0);
        chk("R2 request on fall", req_n, 0);
        for (int i = 0; i < gd; i++) begin
            grant_n = 1'b1;
            tick(1'b1);
            chk("R3 request held", req_n, 0);
            chk("R3 no drive before grant", drv_en, 0);
            grant_n = 1'b0;
            tick(1'b0);
            grant_n = 1'b1;
            chk("R3 grant at fall ignored", drv_en, 0);
        end
        grant_n = 1'b0;
        tick(1'b1);
        chk("R4 no drive at grant rise", drv_en, 0);
        tick(1'b0);
        chk("R4 drive at next fall", drv_en, 1);
        chk("R4 request still low", req_n, 0);
        for (int j = 0; j < ol; j++) begin
            tick(1'b1);
            tick(1'b0);
            chk("R5 held while not done", req_n, 0);
        end
        done = 1'b1;
        tick(1'b1);
        chk("R5 done at rise ignored", req_n, 0);
        cyc_active = (cx > 0);
        tick(1'b0);
        chk("R5 release on fall", req_n, 1);
        chk("R5 drivers kept at release", drv_en, 1);
        done = 1'b0;
        grant_n = 1'b1;
        want = 1'b1;
        drain(cx, r);
        tick(1'b0);
        chk("R9 holdoff gap", req_n, (r >= HOLD) ? 0 : 1);
        while (r < HOLD) begin
            tick(1'b1); r++;
            tick(1'b0);
            chk("R9 request after holdoff", req_n, (r >= HOLD) ? 0 : 1);
        end
        finish_quick();
    endtask

    task automatic run_preempt(input int cx, input bit early);
        int r;
        want = 1'b1;
        tick(1'b1);
        tick(1'b0);
        chk("R2 request", req_n, 0);
        grant_n = 1'b0;
        tick(1'b1);
        tick(1'b0);
        chk("R4 drive", drv_en, 1);
        want = 1'b0;
        grant_n = 1'b1;
        for (int m = 1; m <= LIM - 2; m++) begin
            tick(1'b1);
            chk("R8 no error before limit", preempt_err, 0);
            tick(1'b0);
            chk("R8 still owning before limit", req_n, 0);
        end
        tick(1'b1);
        chk("R8 no error one short", preempt_err, 0);
        cyc_active = (cx > 0);
        if (early) begin
            done = 1'b1;
            tick(1'b0);
            chk("R5 early release", req_n, 1);
            done = 1'b0;
            drain(cx, r);
            chk("R8 no error on early release", preempt_err, 0);
        end else begin
            tick(1'b0);
            chk("R8 still owning one short", req_n, 0);
            tick(1'b1);
            chk("R8 error at limit", preempt_err, 1);
            tick(1'b0);
            chk("R8 forced release", req_n, 1);
            drain(cx, r);
            chk("R10 error sticky", preempt_err, 1);
        end
        tick(1'b0);
        tick(1'b1);
        tick(1'b0);
        want = 1'b1;
        tick(1'b1);
        tick(1'b0);
        chk("R10 request raised", req_n, 0);
        chk("R10 error cleared", preempt_err, 0);
        finish_quick();
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset req", req_n, 1);
        chk("R1 reset drv", drv_en, 0);
        chk("R1 reset err", preempt_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset req", req_n, 1);
        chk("R1 after reset drv", drv_en, 0);
        for (int gd = 0; gd < 4; gd++)
            for (int ol = 0; ol < 3; ol++)
                for (int cx = 0; cx < 3; cx++)
                    run_case(gd, ol, cx);
        for (int cx = 0; cx < 2; cx++) begin
            run_preempt(cx, 1'b0);
            run_preempt(cx, 1'b1);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule